// File: doc/BRIEF.md
# Receive Filter Indirect Memory Port

This block gives a host a narrow window into the address filter storage of an Ethernet receiver. Two stores sit behind it: a six-byte station address used for exact-match filtering and a 256-byte multicast hash table. The host does not address these stores directly. It first writes a filter address into a control register. It then reads or writes one 16-bit word at that filter address through a data register. Accesses that are misaligned or fall outside both stores are flagged and have no effect.

The stored station address is also offered, one 16-bit word at a time, on a side port for an external reader such as a boot-time configuration emulator. A multicast pass signal tells the receive path that every multicast frame is to be accepted whenever the hash enable bit is set, whatever the table holds.

Top module: `rxfilt_port`

## Requirements
- R1: After reset the control register reads zero, every station word and every hash word reads zero, and `err` is low.
- R2: Host register index 0 is the control register. Bits 9:0 hold the filter address and bit 16 holds the hash enable. Every other bit reads zero. A write takes effect on the next cycle.
- R3: Through host register index 1, filter addresses 0x000, 0x002 and 0x004 select station bytes 0–1, 2–3 and 4–5. On a write, `wdata[7:0]` goes to the even byte and `wdata[15:8]` goes to the odd byte.
- R4: A read of a valid data word returns the odd byte in bits 15:8 and the even byte in bits 7:0, with bits 31:16 zero.
- R5: Even filter addresses from 0x100 through 0x1FE reach the hash table. The byte offset is the address minus 0x100, and the word covers the bytes at that offset and the offset plus one.
- R6: A data register access at an odd filter address, or at any address outside the station words and the hash range, raises `err` for exactly the following cycle. Such an access changes no store and reads as zero.
- R7: A read (`sel` high, `we` low) presents its result on `rdata` in the following cycle, and `rdata` holds while no read is made. Host indices 2 and 3 read as zero, and writes to them change nothing.
- R8: `stnWord` shows station word `stnSel` (0, 1 or 2, laid out as in R4) combinationally, and shows zero for `stnSel` equal to 3.
- R9: `mcastPass` is high exactly when `mcastFrame` is high and the hash enable bit is set.
- R10: A station write becomes visible on `stnWord` in the cycle after it is issued. During the issuing cycle `stnWord` still shows the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Host access strobe |
| we | input | 1 | Host write when high, read when low |
| addr | input | 2 | Host register index |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Host read data, one cycle after the read |
| err | output | 1 | One-cycle pulse for a bad filter access |
| stnSel | input | 2 | Station word select for the side reader |
| stnWord | output | 16 | Selected station word |
| mcastFrame | input | 1 | Current frame is multicast |
| mcastPass | output | 1 | Accept the multicast frame regardless of the table |

## Verification
A host write to a station word and a side-port read of that same word can fall in the same cycle. The bench parks `stnSel` on the word being written and drives the write at the falling edge. It then samples `stnWord` just before the next rising edge, where it expects the old value, and again one cycle later, where it expects the new value. Random filter addresses mix good, odd and unmapped cases, and after every rejected write the bench sweeps the side port to confirm the station store is untouched.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
  parameter int FADDR_W     = 10;
  parameter int HOST_AW     = 2;
  parameter int DATA_W      = 32;
  parameter int WORD_W      = 16;
  parameter int STN_WORDS   = 3;
  parameter int HASH_BASE   = 256;
  parameter int HASH_BYTES  = 256;
  parameter int HASH_EN_BIT = 16;

  localparam int HASH_WORDS = HASH_BYTES / 2;
  localparam int HASH_IW    = $clog2(HASH_WORDS);
  localparam int STN_IW     = $clog2(STN_WORDS + 1);

  localparam logic [HOST_AW-1:0] REG_CTL  = HOST_AW'(0);
  localparam logic [HOST_AW-1:0] REG_DATA = HOST_AW'(1);

  typedef struct packed {
    logic               stnWr;
    logic               hashWr;
    logic               rdStn;
    logic               rdHash;
    logic               rdCtl;
    logic               rdAny;
    logic               errAcc;
    logic [HASH_IW-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/rfp_ctrl.sv
module rfp_ctrl
  import rfp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               we,
  input  logic [HOST_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               mcastFrame,
  output strobe_t            stb,
  output logic [DATA_W-1:0]  ctlWord,
  output logic               mcastPass
);
  localparam logic [FADDR_W-1:0] STN_END   = FADDR_W'(STN_WORDS * 2);
  localparam logic [FADDR_W-1:0] HASH_LO   = FADDR_W'(HASH_BASE);
  localparam logic [FADDR_W-1:0] HASH_LAST = FADDR_W'(HASH_BASE + HASH_BYTES - 1);

  logic [FADDR_W-1:0] filtAddr;
  logic               hashEn;
  logic [FADDR_W-1:0] hashOff;
  logic               stnHit;
  logic               hashHit;
  logic               dataAcc;
  logic               ctlAcc;
  logic               unusedBits;

  always_ff @(posedge clk) begin
    if (rst) begin
      filtAddr <= '0;
      hashEn   <= 1'b0;
    end else if (sel && we && addr == REG_CTL) begin
      filtAddr <= wdata[FADDR_W-1:0];
      hashEn   <= wdata[HASH_EN_BIT];
    end
  end

  always_comb begin
    hashOff = filtAddr - HASH_LO;
    stnHit  = (filtAddr < STN_END) && !filtAddr[0];
    hashHit = (filtAddr >= HASH_LO) && (filtAddr <= HASH_LAST) && !filtAddr[0];
    dataAcc = sel && (addr == REG_DATA);
    ctlAcc  = sel && (addr == REG_CTL);
  end

  always_comb begin
    stb        = '0;
    stb.stnWr  = dataAcc && we && stnHit;
    stb.hashWr = dataAcc && we && hashHit;
    stb.rdStn  = dataAcc && !we && stnHit;
    stb.rdHash = dataAcc && !we && hashHit;
    stb.rdCtl  = ctlAcc && !we;
    stb.rdAny  = sel && !we;
    stb.errAcc = dataAcc && !(stnHit || hashHit);
    stb.idx    = stnHit ? filtAddr[HASH_IW:1] : hashOff[HASH_IW:1];
  end

  always_comb begin
    ctlWord                = '0;
    ctlWord[FADDR_W-1:0]   = filtAddr;
    ctlWord[HASH_EN_BIT]   = hashEn;
  end

  assign mcastPass = mcastFrame && hashEn;

  assign unusedBits = ^{wdata, hashOff[FADDR_W-1:HASH_IW+1], hashOff[0],
                        filtAddr[FADDR_W-1:HASH_IW+1]};
endmodule

// File: rtl/rfp_datapath.sv
module rfp_datapath
  import rfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] wrWord,
  input  logic [DATA_W-1:0] ctlWord,
  input  logic [1:0]        stnSel,
  output logic [WORD_W-1:0] stnWord,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  logic [WORD_W-1:0] stnMem  [STN_WORDS];
  logic [WORD_W-1:0] hashMem [HASH_WORDS];
  logic [DATA_W-1:0] rdNext;
  logic [STN_IW-1:0] stnIdx;

  assign stnIdx = stb.idx[STN_IW-1:0];

  // Each station word keeps {odd byte, even byte}; the write lane order
  // falls out of storing the host half-word as is.
  for (genvar w = 0; w < STN_WORDS; w++) begin : g_stn
    always_ff @(posedge clk) begin
      if (rst)
        stnMem[w] <= '0;
      else if (stb.stnWr && stnIdx == STN_IW'(w))
        stnMem[w] <= wrWord;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HASH_WORDS; i++) hashMem[i] <= '0;
    end else if (stb.hashWr) begin
      hashMem[stb.idx] <= wrWord;
    end
  end

  always_comb begin
    rdNext = '0;
    if (stb.rdCtl)
      rdNext = ctlWord;
    else if (stb.rdStn && int'(stnIdx) < STN_WORDS)
      rdNext[WORD_W-1:0] = stnMem[stnIdx];
    else if (stb.rdHash)
      rdNext[WORD_W-1:0] = hashMem[stb.idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      err <= stb.errAcc;
      if (stb.rdAny) rdata <= rdNext;
    end
  end

  always_comb begin
    stnWord = '0;
    if (int'(stnSel) < STN_WORDS) stnWord = stnMem[stnSel];
  end
endmodule

// File: rtl/rxfilt_port.sv
module rxfilt_port
  import rfp_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sel,
  input  logic               we,
  input  logic [HOST_AW-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               err,
  input  logic [1:0]         stnSel,
  output logic [WORD_W-1:0]  stnWord,
  input  logic               mcastFrame,
  output logic               mcastPass
);
  strobe_t           stb;
  logic [DATA_W-1:0] ctlWord;

  rfp_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .we         (we),
    .addr       (addr),
    .wdata      (wdata),
    .mcastFrame (mcastFrame),
    .stb        (stb),
    .ctlWord    (ctlWord),
    .mcastPass  (mcastPass)
  );

  rfp_datapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .wrWord  (wdata[WORD_W-1:0]),
    .ctlWord (ctlWord),
    .stnSel  (stnSel),
    .stnWord (stnWord),
    .rdata   (rdata),
    .err     (err)
  );
endmodule

// File: rtl/rxfilt_port_chk.sv
module rxfilt_port_chk
  import rfp_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               sel,
  input logic               we,
  input logic [HOST_AW-1:0] addr,
  input logic [DATA_W-1:0]  rdata,
  input logic               err,
  input logic [1:0]         stnSel,
  input logic [WORD_W-1:0]  stnWord,
  input logic               mcastFrame,
  input logic               mcastPass
);
  // R6: an error pulse only ever follows a data register access
  a_r6_err_after_data: assert property (@(posedge clk) disable iff (rst)
    err |-> ($past(sel) && $past(addr) == REG_DATA));

  // R7: read data holds while no read is made
  a_r7_rdata_holds: assert property (@(posedge clk) disable iff (rst)
    !(sel && !we) |=> $stable(rdata));

  // R8: the unused station select shows zero
  a_r8_sel3_zero: assert property (@(posedge clk) disable iff (rst)
    (stnSel == 2'd3) |-> (stnWord == '0));

  // R9: multicast pass never rises without a multicast frame
  a_r9_pass_needs_frame: assert property (@(posedge clk) disable iff (rst)
    mcastPass |-> mcastFrame);

  // R10: without a host write the selected station word does not move
  a_r10_stn_stable: assert property (@(posedge clk) disable iff (rst)
    !(sel && we) |=> (stnSel != $past(stnSel) || $stable(stnWord)));
endmodule

bind rxfilt_port rxfilt_port_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sel        (sel),
  .we         (we),
  .addr       (addr),
  .rdata      (rdata),
  .err        (err),
  .stnSel     (stnSel),
  .stnWord    (stnWord),
  .mcastFrame (mcastFrame),
  .mcastPass  (mcastPass)
);

// File: tb/rxfilt_port_bench.sv
module rxfilt_port_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        err;
  logic [1:0]  stnSel = '0;
  logic [15:0] stnWord;
  logic        mcastFrame = 1'b0;
  logic        mcastPass;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] mStn [6];
  logic [7:0] mHash [256];
  int         mAddr = 0;
  bit         mEn = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxfilt_port u_rxfilt_port (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .err(err), .stnSel(stnSel), .stnWord(stnWord),
    .mcastFrame(mcastFrame), .mcastPass(mcastPass)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit isStn(input int a);
    return a < 6 && a % 2 == 0;
  endfunction

  function automatic bit isHash(input int a);
    return a >= 256 && a < 512 && a % 2 == 0;
  endfunction

  function automatic logic [31:0] expWord(input int a);
    if (isStn(a)) return {16'h0, mStn[a + 1], mStn[a]};
    if (isHash(a)) return {16'h0, mHash[a - 255], mHash[a - 256]};
    return 32'h0;
  endfunction

  function automatic logic [31:0] expCtl();
    logic [31:0] v = '0;
    v[9:0] = 10'(mAddr);
    v[16] = mEn;
    return v;
  endfunction

  task automatic hostWr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic hostRd(input logic [1:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata; e = err;
  endtask

  task automatic setCtl(input int a, input bit en);
    hostWr(2'd0, {15'h0, en, 6'h0, 10'(a)});
    mAddr = a; mEn = en;
  endtask

  task automatic sweepStn(input string req);
    for (int k = 0; k < 3; k++) begin
      stnSel = 2'(k);
      #1;
      check(req, {16'h0, stnWord}, {16'h0, mStn[2 * k + 1], mStn[2 * k]});
    end
  endtask

  task automatic dataWr(input logic [15:0] d);
    bit good = isStn(mAddr) || isHash(mAddr);
    hostWr(2'd1, {16'hdead, d});
    check(good ? "R3/R5 err on good write" : "R6 err on bad write", {31'h0, err}, {31'h0, !good});
    if (isStn(mAddr)) begin
      mStn[mAddr] = d[7:0]; mStn[mAddr + 1] = d[15:8];
    end else if (isHash(mAddr)) begin
      mHash[mAddr - 256] = d[7:0]; mHash[mAddr - 255] = d[15:8];
    end
    @(negedge clk);
    check("R6 err lasts one cycle", {31'h0, err}, 32'h0);
    if (!good) sweepStn("R6 bad write leaves station store");
  endtask

  task automatic dataRd(input string req);
    logic [31:0] d;
    logic e;
    bit good = isStn(mAddr) || isHash(mAddr);
    hostRd(2'd1, d, e);
    check(req, d, expWord(mAddr));
    check(good ? "R4 err on good read" : "R6 err on bad read", {31'h0, e}, {31'h0, !good});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    void'($urandom(32'd4711));
    for (int i = 0; i < 6; i++) mStn[i] = 8'h0;
    for (int i = 0; i < 256; i++) mHash[i] = 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 err after reset", {31'h0, err}, 32'h0);
    hostRd(2'd0, d, e);
    check("R1 control after reset", d, 32'h0);
    sweepStn("R1 station after reset");
    setCtl(16'h1fe, 0);
    dataRd("R1 hash word after reset");

    // R2 control field layout, reserved bits read zero
    hostWr(2'd0, 32'hffff_ffff);
    mAddr = 10'h3ff; mEn = 1;
    hostRd(2'd0, d, e);
    check("R2 control readback", d, 32'h0001_03ff);

    // R3/R4 station lanes
    setCtl(0, 0);  dataWr(16'h2211);
    setCtl(2, 0);  dataWr(16'h4433);
    setCtl(4, 0);  dataWr(16'h6655);
    sweepStn("R3 station bytes by lane");
    setCtl(2, 0);  dataRd("R4 station word read order");
    check("R4 byte order word 2", {16'h0, mStn[5], mStn[4]}, 32'h0000_6655);

    // R5 hash bounds
    setCtl(256, 1); dataWr(16'hbeef); dataRd("R5 hash first word");
    setCtl(510, 1); dataWr(16'hcafe); dataRd("R5 hash last word");

    // R6 bad addresses
    setCtl(1, 0);   dataWr(16'h1234); dataRd("R6 odd station read zero");
    setCtl(6, 0);   dataWr(16'h1234); dataRd("R6 gap read zero");
    setCtl(257, 0); dataWr(16'h1234); dataRd("R6 odd hash read zero");
    setCtl(512, 0); dataWr(16'h1234); dataRd("R6 above hash read zero");
    setCtl(510, 0); dataRd("R6 hash last word unchanged");

    // R7 latency, hold, unused indices
    setCtl(0, 0);
    hostRd(2'd1, d, e);
    check("R7 read next cycle", d, 32'h0000_2211);
    @(negedge clk); @(negedge clk);
    check("R7 rdata holds", rdata, 32'h0000_2211);
    hostWr(2'd2, 32'hffff_ffff);
    hostWr(2'd3, 32'hffff_ffff);
    hostRd(2'd2, d, e);
    check("R7 index 2 reads zero", d, 32'h0);
    hostRd(2'd3, d, e);
    check("R7 index 3 reads zero", d, 32'h0);
    hostRd(2'd0, d, e);
    check("R7 unused writes ignored", d, expCtl());
    sweepStn("R7 unused writes leave station");

    // R8 unused select
    stnSel = 2'd3; #1;
    check("R8 select 3 zero", {16'h0, stnWord}, 32'h0);

    // R9 multicast pass
    setCtl(0, 1);
    mcastFrame = 1'b1; #1;
    check("R9 pass with enable", {31'h0, mcastPass}, 32'h1);
    mcastFrame = 1'b0; #1;
    check("R9 no frame", {31'h0, mcastPass}, 32'h0);
    setCtl(0, 0);
    mcastFrame = 1'b1; #1;
    check("R9 enable off", {31'h0, mcastPass}, 32'h0);
    mcastFrame = 1'b0;

    // R10 write and side read in the same cycle
    setCtl(2, 0);
    stnSel = 2'd1;
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = 2'd1; wdata = 32'h0000_a5c3;
    #(CLK_PERIOD / 2 - 1);
    check("R10 old value in write cycle", {16'h0, stnWord}, 32'h0000_4433);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
    check("R10 new value next cycle", {16'h0, stnWord}, 32'h0000_a5c3);
    mStn[2] = 8'hc3; mStn[3] = 8'ha5;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int kind = int'($urandom % 4);
      int a;
      case (kind)
        0: a = 2 * int'($urandom % 3);
        1: a = 256 + 2 * int'($urandom % 128);
        2: a = 2 * int'($urandom % 512) + 1;
        default: a = ($urandom % 2 == 0) ? 6 + 2 * int'($urandom % 125)
                                         : 512 + 2 * int'($urandom % 256);
      endcase
      setCtl(a, 1'($urandom));
      if ($urandom % 2 == 0) dataWr(16'($urandom));
      else dataRd("R3/R5/R6 random read");
      if (it % 50 == 0) begin
        hostRd(2'd0, d, e);
        check("R2 random control readback", d, expCtl());
      end
    end
    sweepStn("R3 final station sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule